// File: doc/BRIEF.md
# Array Access Microcode Sequencer

This block turns one microcoded array instruction into a short, fixed run of internal 8-bit opcodes for the execution pipeline. Each opcode comes with a 16-bit operand. The instruction translator hands over a microcode address through a valid/ready start handshake. The sequencer then presents one opcode at a time on a valid/ready issue handshake and moves to the next step only when the pipeline accepts the current one. Until the sequence is over, the start ready stays low, so the translator is stalled.

Two sequences are built in, one for an array read and one for an array write. Both form the element address as reference + (index << 2) + 4 using ordinary stack opcodes. The write sequence also uses two scratch global registers, so that the value to be stored survives the address arithmetic. The stack, the global registers and memory belong to the execution unit and lie outside this block.

Top module: `array_ucode_seq`

## Requirements
- R1: During reset and right after it, start_ready_o is 1, and op_valid_o, seq_done_o and seq_err_o are 0.
- R2: An accepted start with address 8'h01 issues, in order: 8'h40 (push), 8'hC1 (shift left), 8'h40 (push), 8'h30 (add), 8'h30 (add), 8'h12 (load word).
- R3: An accepted start with address 8'h02 issues, in order: 8'hFA (write scratch 0), 8'h40, 8'hC1, 8'h40, 8'h30, 8'h30, 8'hFB (write scratch 1), 8'hF2 (read scratch 0), 8'hF3 (read scratch 1), 8'h22 (store word).
- R4: The first push of either sequence carries operand 2 and the second push carries operand 4. Every other step carries operand 0.
- R5: op_valid_o rises in the cycle after the start is accepted, with op_step_o at 0. op_step_o then goes up by one after each transfer (op_valid_o and op_ready_i both high).
- R6: While op_valid_o is high and op_ready_i is low, op_code_o, op_operand_o and op_step_o hold their values and the sequence does not advance.
- R7: start_ready_o is low while a sequence is being issued and for one cycle after its final transfer. A start_valid_i in those cycles is ignored.
- R8: seq_done_o is high for exactly one cycle: the cycle in which the final opcode of the sequence is transferred.
- R9: A start with any address other than 8'h01 or 8'h02 raises seq_err_o in its accept cycle. No opcode is issued, and start_ready_o stays high.
- R10: After the turnaround cycle that follows a done, a new start is accepted and its sequence begins again at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Translator requests a microcoded instruction |
| start_addr_i | input | 8 | Microcode address of the request |
| start_ready_o | output | 1 | Sequencer is idle and takes a request |
| op_valid_o | output | 1 | An opcode is offered to the pipeline |
| op_code_o | output | 8 | Opcode of the current step |
| op_operand_o | output | 16 | Execution operand of the current step |
| op_step_o | output | 4 | Index of the current step |
| op_ready_i | input | 1 | Pipeline takes the offered opcode |
| seq_done_o | output | 1 | Final opcode is being transferred |
| seq_err_o | output | 1 | Start request carried an unknown address |

## Verification
Both sequences are run with the pipeline ready held high, which shows the step order and operands at full rate. They are also run with ready dropped at random and for long stretches, which separates a design that advances on valid alone from one that waits for the handshake. Starts arrive while a sequence is running, in the turnaround cycle and back to back after a done, so a sequencer that takes requests too early or too late shows up. Known and unknown addresses are mixed, so the error path can be told apart from the two real decodes.

// File: rtl/aseq_pkg.sv
package aseq_pkg;
  typedef logic [7:0] opc_t;

  localparam opc_t OPC_NOP  = 8'h00;
  localparam opc_t OPC_PUSH = 8'h40;
  localparam opc_t OPC_SHL  = 8'hC1;
  localparam opc_t OPC_ADD  = 8'h30;
  localparam opc_t OPC_LDW  = 8'h12;
  localparam opc_t OPC_STW  = 8'h22;
  localparam opc_t OPC_WG0  = 8'hFA;
  localparam opc_t OPC_WG1  = 8'hFB;
  localparam opc_t OPC_RG0  = 8'hF2;
  localparam opc_t OPC_RG1  = 8'hF3;

  localparam int LOAD_LEN  = 6;
  localparam int STORE_LEN = 10;
  localparam int MAX_LEN   = (LOAD_LEN > STORE_LEN) ? LOAD_LEN : STORE_LEN;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;
  typedef enum logic {SQ_LOAD, SQ_STORE} seq_t;
endpackage

// File: rtl/aseq_rst_sync.sv
module aseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/aseq_rom.sv
module aseq_rom
  import aseq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int OPND_W = 16
) (
  input  seq_t              sel,
  input  logic [STEP_W-1:0] step,
  output opc_t              opcode,
  output logic [OPND_W-1:0] operand,
  output logic              last
);
  localparam logic [OPND_W-1:0] SCALE_SH = OPND_W'(2);
  localparam logic [OPND_W-1:0] HDR_OFS  = OPND_W'(4);

  always_comb begin
    opcode  = OPC_NOP;
    operand = '0;
    last    = 1'b0;
    if (sel == SQ_LOAD) begin
      case (step)
        STEP_W'(0): begin opcode = OPC_PUSH; operand = SCALE_SH; end
        STEP_W'(1): opcode = OPC_SHL;
        STEP_W'(2): begin opcode = OPC_PUSH; operand = HDR_OFS; end
        STEP_W'(3): opcode = OPC_ADD;
        STEP_W'(4): opcode = OPC_ADD;
        STEP_W'(5): begin opcode = OPC_LDW; last = 1'b1; end
        default:    opcode = OPC_NOP;
      endcase
    end else begin
      case (step)
        STEP_W'(0): opcode = OPC_WG0;
        STEP_W'(1): begin opcode = OPC_PUSH; operand = SCALE_SH; end
        STEP_W'(2): opcode = OPC_SHL;
        STEP_W'(3): begin opcode = OPC_PUSH; operand = HDR_OFS; end
        STEP_W'(4): opcode = OPC_ADD;
        STEP_W'(5): opcode = OPC_ADD;
        STEP_W'(6): opcode = OPC_WG1;
        STEP_W'(7): opcode = OPC_RG0;
        STEP_W'(8): opcode = OPC_RG1;
        STEP_W'(9): begin opcode = OPC_STW; last = 1'b1; end
        default:    opcode = OPC_NOP;
      endcase
    end
  end
endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl
  import aseq_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              STEP_W     = 4,
  parameter logic [ADDR_W-1:0] LOAD_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] STORE_ADDR = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              start_ready,
  output logic              op_valid,
  input  logic              op_ready,
  input  logic              rom_last,
  output seq_t              sel,
  output logic [STEP_W-1:0] step,
  output logic              seq_done,
  output logic              seq_err
);
  state_t            state_q, state_d;
  seq_t              sel_q, sel_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              sel_en, step_en;
  logic              accept, known, fire;

  assign known  = (start_addr == LOAD_ADDR) || (start_addr == STORE_ADDR);
  assign accept = start_valid && (state_q == ST_IDLE);
  assign fire   = (state_q == ST_RUN) && op_ready;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    step_d  = step_q;
    sel_en  = 1'b0;
    step_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept && known) begin
          state_d = ST_RUN;
          sel_d   = (start_addr == STORE_ADDR) ? SQ_STORE : SQ_LOAD;
          sel_en  = 1'b1;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (fire) begin
          if (rom_last) begin
            state_d = ST_DONE;
          end else begin
            step_d  = step_q + STEP_W'(1);
            step_en = 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= SQ_LOAD;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (sel_en)  sel_q  <= sel_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign start_ready = (state_q == ST_IDLE);
  assign op_valid    = (state_q == ST_RUN);
  assign sel         = sel_q;
  assign step        = step_q;
  assign seq_done    = fire && rom_last;
  assign seq_err     = accept && !known;

  // R5: each transfer that is not the last moves the step index up by one
  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !seq_done) |=> (op_valid && step == $past(step) + STEP_W'(1)));

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R7: no new request is taken in the cycle after the final transfer
  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!start_ready && !op_valid));

  // R9: an unknown address leaves the sequencer idle
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (start_ready && !op_valid));

  // R10: a known address accepted while idle starts at step 0
  a_r10_start_step0: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && !seq_err) |=> (op_valid && step == '0));
endmodule

// File: rtl/array_ucode_seq.sv
module array_ucode_seq
  import aseq_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              STEP_W     = 4,
  parameter int              OPND_W     = 16,
  parameter logic [ADDR_W-1:0] LOAD_ADDR  = ADDR_W'(1),
  parameter logic [ADDR_W-1:0] STORE_ADDR = ADDR_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              start_ready_o,
  output logic              op_valid_o,
  output logic [7:0]        op_code_o,
  output logic [OPND_W-1:0] op_operand_o,
  output logic [STEP_W-1:0] op_step_o,
  input  logic              op_ready_i,
  output logic              seq_done_o,
  output logic              seq_err_o
);
  localparam int STEP_CAP = 1 << STEP_W;

  logic              rst_n_int;
  seq_t              sel;
  logic [STEP_W-1:0] step;
  logic              rom_last;
  opc_t              rom_opc;

  initial begin
    if (STEP_CAP < MAX_LEN) $error("step counter too narrow for the longest sequence");
  end

  aseq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  aseq_ctrl #(
    .ADDR_W    (ADDR_W),
    .STEP_W    (STEP_W),
    .LOAD_ADDR (LOAD_ADDR),
    .STORE_ADDR(STORE_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_valid(start_valid_i),
    .start_addr (start_addr_i),
    .start_ready(start_ready_o),
    .op_valid   (op_valid_o),
    .op_ready   (op_ready_i),
    .rom_last   (rom_last),
    .sel        (sel),
    .step       (step),
    .seq_done   (seq_done_o),
    .seq_err    (seq_err_o)
  );

  aseq_rom #(.STEP_W(STEP_W), .OPND_W(OPND_W)) u_rom (
    .sel    (sel),
    .step   (step),
    .opcode (rom_opc),
    .operand(op_operand_o),
    .last   (rom_last)
  );

  assign op_code_o = rom_opc;
  assign op_step_o = step;

  // R6: a stalled opcode stays put until the pipeline takes it
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_valid_o && !op_ready_i) |=> (op_valid_o && $stable(op_code_o)
                                     && $stable(op_operand_o) && $stable(op_step_o)));

  // R4: only push steps carry a non-zero operand
  a_r4_operand_push_only: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op_valid_o && op_code_o != OPC_PUSH) |-> (op_operand_o == '0));

  // R8: done only with an actual transfer of a final opcode
  a_r8_done_on_final: assert property (@(posedge clk) disable iff (!rst_n_int)
    seq_done_o |-> (op_valid_o && op_ready_i && (op_code_o == OPC_LDW || op_code_o == OPC_STW)));

  // R7: translator is stalled while opcodes are offered
  a_r7_stall_running: assert property (@(posedge clk) disable iff (!rst_n_int)
    op_valid_o |-> !start_ready_o);
endmodule

// File: tb/array_ucode_seq_test.sv
module array_ucode_seq_test;
  logic        clk;
  logic        rst_n;
  logic        start_valid_i;
  logic [7:0]  start_addr_i;
  logic        start_ready_o;
  logic        op_valid_o;
  logic [7:0]  op_code_o;
  logic [15:0] op_operand_o;
  logic [3:0]  op_step_o;
  logic        op_ready_i;
  logic        seq_done_o;
  logic        seq_err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 running, 2 turnaround
  int m_state = 0;
  int m_store = 0;
  int m_step  = 0;

  array_ucode_seq uut (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_addr_i(start_addr_i),
    .start_ready_o(start_ready_o), .op_valid_o(op_valid_o),
    .op_code_o(op_code_o), .op_operand_o(op_operand_o),
    .op_step_o(op_step_o), .op_ready_i(op_ready_i),
    .seq_done_o(seq_done_o), .seq_err_o(seq_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_len(int st);
    return st ? 10 : 6;
  endfunction

  function automatic logic [7:0] exp_opc(int st, int idx);
    logic [7:0] ld [6]  = '{8'h40, 8'hC1, 8'h40, 8'h30, 8'h30, 8'h12};
    logic [7:0] sr [10] = '{8'hFA, 8'h40, 8'hC1, 8'h40, 8'h30, 8'h30,
                            8'hFB, 8'hF2, 8'hF3, 8'h22};
    return st ? sr[idx] : ld[idx];
  endfunction

  function automatic logic [15:0] exp_opnd(int st, int idx);
    int first = st ? 1 : 0;
    if (idx == first)     return 16'd2;
    if (idx == first + 2) return 16'd4;
    return 16'd0;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one clock cycle: drive inputs, compare outputs with the model, advance model
  task automatic cyc(bit sv, logic [7:0] addr, bit rdy);
    bit known, last, valid;
    @(negedge clk);
    start_valid_i = sv;
    start_addr_i  = addr;
    op_ready_i    = rdy;
    #1;
    known = (addr == 8'h01) || (addr == 8'h02);
    valid = (m_state == 1);
    last  = valid && (m_step == exp_len(m_store) - 1);
    chk("R7", "start_ready", start_ready_o, m_state == 0);
    chk("R5", "op_valid", op_valid_o, valid);
    if (valid) begin
      chk(m_store ? "R3" : "R2", "op_code", op_code_o, exp_opc(m_store, m_step));
      chk("R4", "op_operand", op_operand_o, exp_opnd(m_store, m_step));
      chk("R5", "op_step", op_step_o, m_step);
    end
    chk("R8", "seq_done", seq_done_o, valid && rdy && last);
    chk("R9", "seq_err", seq_err_o, sv && m_state == 0 && !known);
    case (m_state)
      0: if (sv && known) begin m_state = 1; m_store = (addr == 8'h02); m_step = 0; end
      1: if (rdy) begin
           if (last) m_state = 2;
           else      m_step++;
         end
      default: m_state = 0;
    endcase
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    start_valid_i = 1'b0;
    start_addr_i  = 8'h00;
    op_ready_i    = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "start_ready", start_ready_o, 1);
    chk("R1", "op_valid", op_valid_o, 0);
    chk("R1", "seq_done", seq_done_o, 0);
    chk("R1", "seq_err", seq_err_o, 0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 8'h00, 0);

    // R2: array read at full rate, then R10 back-to-back store
    cyc(1, 8'h01, 1);
    repeat (6) cyc(0, 8'h00, 1);
    cyc(1, 8'h02, 1);  // turnaround cycle: ignored (R7)
    cyc(1, 8'h02, 1);  // R10: accepted
    repeat (10) cyc(1, 8'h01, 1);  // R7: starts during run ignored
    cyc(0, 8'h00, 1);
    // R9: unknown addresses
    cyc(1, 8'h00, 1);
    cyc(1, 8'hFF, 1);
    cyc(1, 8'h03, 0);
    // R6: long stalls inside a store
    cyc(1, 8'h02, 0);
    for (int i = 0; i < 10; i++) begin
      repeat (3) cyc(0, 8'h00, 0);
      cyc(0, 8'h00, 1);
    end
    repeat (2) cyc(0, 8'h00, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 9);
      logic [7:0] a = (pick < 4) ? 8'h01 : (pick < 8) ? 8'h02 : 8'($urandom);
      cyc($urandom_range(0, 2) != 0, a, $urandom_range(0, 9) < 7);
    end
    summary();
  end
endmodule